// File: doc/BRIEF.md
# Per-Port Congestion and Broadcast-Storm Controller

This block sits beside the shared frame buffer of a multi-port switch and decides, every clock, whether the buffer is congested. It compares the buffer occupancy against two programmable watermarks with hysteresis. Congestion begins when occupancy climbs above the upper (warning) mark. It ends only when occupancy falls below the lower (release) mark.

While congestion lasts, each port is throttled according to its duplex mode. A half-duplex port that is receiving a frame gets a jam (back-pressure) request. A full-duplex port that has been receiving gets a PAUSE request with the maximum pause time. That request is refreshed periodically, and a PAUSE with zero time follows when congestion ends. A separate counter tracks broadcast frames held in the buffer. New broadcast frames are dropped while that count is at or above a programmable limit.

The thresholds are loaded through a small write port.

Top module: `congest_ctrl`

## Requirements
- R1: The `congested` output rises one clock after a cycle in which `occ` is strictly greater than the warning threshold. `occ` equal to the warning threshold does not start congestion.
- R2: Once `congested` is high, it stays high while `occ` is at or above the effective release level. It falls one clock after a cycle in which `occ` is strictly below that level.
- R3: The effective release level is the release register when that register is strictly below the warning register. Otherwise it is warning minus one, or zero when the warning register is zero.
- R4: `jam_req[i]` is high exactly while `congested` is high, port i is half duplex (`port_fdx[i]`=0) and `port_rx_busy[i]` is high. It follows `port_rx_busy` in the same cycle.
- R5: A full-duplex port that is not yet paused, and that sees `congested` high together with its `port_rx_busy`, raises `pause_req` for one clock with `pause_max`=1 on the next clock. `pause_max` is 0 whenever `pause_req` is 0.
- R6: While congestion persists, every paused full-duplex port repeats its maximum-time PAUSE request. The repeats fall REFRESH_CYC clocks after congestion began and every REFRESH_CYC clocks after that.
- R7: A paused port issues one PAUSE request with `pause_max`=0 on the clock after congestion ends, or after the port turns half duplex. It is then no longer paused.
- R8: `frm_drop` is high in the same cycle as a broadcast frame offer (`frm_valid`=1, `frm_bcast`=1) when the stored broadcast count is at or above the broadcast limit.
- R9: A frame offer with `frm_bcast`=0 never raises `frm_drop`, whatever the broadcast count.
- R10: An admitted broadcast offer adds one to the broadcast count and a `bc_free` pulse subtracts one. Both together leave the count unchanged, and a free at zero leaves the count at zero.
- R11: Writes with `cfg_we`=1 load `cfg_wdata` into the register at `cfg_addr`: 0 warning, 1 release, 2 broadcast limit (low BC_W bits), with 3 ignored. A written value is used from the next clock on.
- R12: After reset the warning and broadcast-limit registers are all ones and the release register is zero. All outputs are low and nothing is congested or paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Threshold register write enable |
| cfg_addr | input | 2 | Threshold register select |
| cfg_wdata | input | OCC_W | Threshold write data |
| occ | input | OCC_W | Current shared buffer occupancy (queue status) |
| port_fdx | input | NPORT | Per-port duplex mode, 1 = full duplex |
| port_rx_busy | input | NPORT | Per-port receive activity (frame in progress) |
| frm_valid | input | 1 | A received frame is offered for buffering |
| frm_bcast | input | 1 | The offered frame is a broadcast |
| bc_free | input | 1 | One stored broadcast frame has been freed |
| congested | output | 1 | Buffer congestion state |
| jam_req | output | NPORT | Back-pressure jam request per half-duplex port |
| pause_req | output | NPORT | One-clock PAUSE frame request per port |
| pause_max | output | NPORT | With pause_req: 1 = maximum pause time, 0 = zero time |
| frm_drop | output | 1 | Drop the offered broadcast frame |

## Verification
The congestion state is due one clock after the occupancy sample that moves it. PAUSE requests are due one clock after the congestion state or the receive activity that triggers them. Jam requests and the drop decision are combinational and due in the same cycle as their inputs. The bench drives inputs just after the falling edge and samples all outputs a moment later. At that point the state reflects the previous rising edge and the combinational outputs reflect the fresh inputs. A reference model in the bench, advanced on each rising edge, supplies the expected value for that exact cycle. Directed checks count the same edges to confirm hysteresis, clamping, refresh spacing and counter saturation.

// File: rtl/congest_pkg.sv
package congest_pkg;
  typedef enum logic [1:0] {
    CFG_WARN  = 2'd0,
    CFG_REL   = 2'd1,
    CFG_BCLIM = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_addr_e;
endpackage

// File: rtl/cg_cfg_regs.sv
module cg_cfg_regs
  import congest_pkg::*;
#(
  parameter int OCC_W = 12,
  parameter int BC_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [OCC_W-1:0] wdata,
  output logic [OCC_W-1:0] warn_q,
  output logic [OCC_W-1:0] rel_q,
  output logic [BC_W-1:0]  bclim_q
);
  logic [OCC_W-1:0] warn_d, rel_d;
  logic [BC_W-1:0]  bclim_d;

  always_comb begin
    warn_d  = warn_q;
    rel_d   = rel_q;
    bclim_d = bclim_q;
    if (we) begin
      case (cfg_addr_e'(addr))
        CFG_WARN:  warn_d  = wdata;
        CFG_REL:   rel_d   = wdata;
        CFG_BCLIM: bclim_d = wdata[BC_W-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q  <= '1;
      rel_q   <= '0;
      bclim_q <= '1;
    end else begin
      warn_q  <= warn_d;
      rel_q   <= rel_d;
      bclim_q <= bclim_d;
    end
  end

  // R11: a write to the warning slot is visible on the next clock
  a_r11_warn_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd0) |=> (warn_q == $past(wdata)));
  // R11: address 3 changes nothing
  a_r11_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd3) |=> ($stable(warn_q) && $stable(rel_q) && $stable(bclim_q)));
endmodule

// File: rtl/cg_watermark.sv
module cg_watermark #(
  parameter int OCC_W       = 12,
  parameter int REFRESH_CYC = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] occ,
  input  logic [OCC_W-1:0] warn,
  input  logic [OCC_W-1:0] rel,
  output logic             cong_q,
  output logic             tick
);
  localparam int CNT_W = (REFRESH_CYC > 2) ? $clog2(REFRESH_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REFRESH_CYC - 1);

  logic [OCC_W-1:0] rel_eff;
  logic             cong_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // release level clamped strictly below the warning level
  always_comb begin
    if (rel < warn)      rel_eff = rel;
    else if (warn == '0) rel_eff = '0;
    else                 rel_eff = warn - 1'b1;
  end

  always_comb begin
    cong_d = cong_q;
    if (!cong_q && (occ > warn))        cong_d = 1'b1;
    else if (cong_q && (occ < rel_eff)) cong_d = 1'b0;
  end

  assign tick = cong_q && (cnt_q == LAST);

  always_comb begin
    if (!cong_q)    cnt_d = '0;
    else if (tick)  cnt_d = '0;
    else            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cong_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cong_q <= cong_d;
      cnt_q  <= cnt_d;
    end
  end

  a_r1_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (!cong_q && occ > warn) |=> cong_q);
  a_r1_no_enter_at_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (!cong_q && occ <= warn) |=> !cong_q);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cong_q && occ >= rel && rel < warn) |=> cong_q);
  a_r3_clamped_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cong_q && rel >= warn && warn != '0 && occ < warn - 1'b1) |=> !cong_q);
  a_r6_tick_only_congested: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> cong_q);
endmodule

// File: rtl/cg_port_ctl.sv
module cg_port_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cong,
  input  logic tick,
  input  logic fdx,
  input  logic rx_busy,
  output logic jam,
  output logic pause_req_q,
  output logic pause_max_q
);
  logic paused_q, paused_d;
  logic pause_req_d, pause_max_d;

  assign jam = cong && !fdx && rx_busy;

  always_comb begin
    paused_d    = paused_q;
    pause_req_d = 1'b0;
    pause_max_d = 1'b0;
    if (paused_q && (!cong || !fdx)) begin
      pause_req_d = 1'b1;
      paused_d    = 1'b0;
    end else if (paused_q && tick) begin
      pause_req_d = 1'b1;
      pause_max_d = 1'b1;
    end else if (!paused_q && cong && fdx && rx_busy) begin
      pause_req_d = 1'b1;
      pause_max_d = 1'b1;
      paused_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused_q    <= 1'b0;
      pause_req_q <= 1'b0;
      pause_max_q <= 1'b0;
    end else begin
      paused_q    <= paused_d;
      pause_req_q <= pause_req_d;
      pause_max_q <= pause_max_d;
    end
  end

  a_r5_max_needs_cong: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req_q && pause_max_q) |-> $past(cong && fdx));
  a_r5_max_only_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    pause_max_q |-> pause_req_q);
  a_r7_zero_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req_q && !pause_max_q) |-> $past(!cong || !fdx));
endmodule

// File: rtl/cg_bcast_gate.sv
module cg_bcast_gate #(
  parameter int BC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frm_valid,
  input  logic            frm_bcast,
  input  logic            bc_free,
  input  logic [BC_W-1:0] bclim,
  output logic            drop
);
  logic [BC_W-1:0] bcnt_q, bcnt_d;
  logic            offer, admit;

  assign offer = frm_valid && frm_bcast;
  assign drop  = offer && (bcnt_q >= bclim);
  assign admit = offer && !drop;

  always_comb begin
    bcnt_d = bcnt_q;
    if (admit && !bc_free)                      bcnt_d = bcnt_q + 1'b1;
    else if (!admit && bc_free && bcnt_q != '0) bcnt_d = bcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt_q <= '0;
    else        bcnt_q <= bcnt_d;
  end

  a_r9_only_bcast_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> (frm_valid && frm_bcast));
  a_r10_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_bcast && !drop && !bc_free) |=> (bcnt_q == $past(bcnt_q) + 1'b1));
  a_r10_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (bcnt_q == '0 && !(frm_valid && frm_bcast)) |=> (bcnt_q == '0));
endmodule

// File: rtl/congest_ctrl.sv
module congest_ctrl #(
  parameter int NPORT       = 12,
  parameter int OCC_W       = 12,
  parameter int BC_W        = 8,
  parameter int REFRESH_CYC = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [OCC_W-1:0] cfg_wdata,
  input  logic [OCC_W-1:0] occ,
  input  logic [NPORT-1:0] port_fdx,
  input  logic [NPORT-1:0] port_rx_busy,
  input  logic             frm_valid,
  input  logic             frm_bcast,
  input  logic             bc_free,
  output logic             congested,
  output logic [NPORT-1:0] jam_req,
  output logic [NPORT-1:0] pause_req,
  output logic [NPORT-1:0] pause_max,
  output logic             frm_drop
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [OCC_W-1:0] warn, rel;
  logic [BC_W-1:0]  bclim;
  logic             tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cg_cfg_regs #(.OCC_W(OCC_W), .BC_W(BC_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .warn_q(warn), .rel_q(rel), .bclim_q(bclim)
  );

  cg_watermark #(.OCC_W(OCC_W), .REFRESH_CYC(REFRESH_CYC)) u_wm (
    .clk(clk), .rst_n(rst_int_n), .occ(occ), .warn(warn), .rel(rel),
    .cong_q(congested), .tick(tick)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    cg_port_ctl u_port (
      .clk(clk), .rst_n(rst_int_n), .cong(congested), .tick(tick),
      .fdx(port_fdx[p]), .rx_busy(port_rx_busy[p]),
      .jam(jam_req[p]), .pause_req_q(pause_req[p]), .pause_max_q(pause_max[p])
    );
  end

  cg_bcast_gate #(.BC_W(BC_W)) u_bc (
    .clk(clk), .rst_n(rst_int_n), .frm_valid(frm_valid), .frm_bcast(frm_bcast),
    .bc_free(bc_free), .bclim(bclim), .drop(frm_drop)
  );

  // R4: no jam toward a full-duplex port
  a_r4_no_jam_fdx: assert property (@(posedge clk) disable iff (!rst_int_n)
    (jam_req & port_fdx) == '0);
  // R12: nothing requested while the buffer is calm and nothing is paused
  a_r12_quiet_when_calm: assert property (@(posedge clk) disable iff (!rst_int_n)
    !congested |-> (jam_req == '0));
endmodule

// File: tb/congest_ctrl_tb.sv
module congest_ctrl_tb;
  localparam int NP = 12;
  localparam int OW = 12;
  localparam int BW = 8;
  localparam int RC = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [OW-1:0] cfg_wdata = '0;
  logic [OW-1:0] occ = '0;
  logic [NP-1:0] port_fdx = '0;
  logic [NP-1:0] port_rx_busy = '0;
  logic          frm_valid = 1'b0, frm_bcast = 1'b0, bc_free = 1'b0;
  logic          congested, frm_drop;
  logic [NP-1:0] jam_req, pause_req, pause_max;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;

  always #2.5 clk = ~clk;

  congest_ctrl #(.NPORT(NP), .OCC_W(OW), .BC_W(BW), .REFRESH_CYC(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .occ(occ), .port_fdx(port_fdx), .port_rx_busy(port_rx_busy),
    .frm_valid(frm_valid), .frm_bcast(frm_bcast), .bc_free(bc_free),
    .congested(congested), .jam_req(jam_req), .pause_req(pause_req),
    .pause_max(pause_max), .frm_drop(frm_drop)
  );

  // reference model, written from the requirements
  logic [OW-1:0] m_warn, m_rel;
  logic [BW-1:0] m_bcl;
  logic          m_cong;
  int            m_cnt, m_bcnt;
  logic [NP-1:0] m_paused, m_preq, m_pmax;

  function automatic logic [OW-1:0] rel_level(logic [OW-1:0] w, logic [OW-1:0] r);
    if (r < w) return r;
    if (w == '0) return '0;
    return w - 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_warn <= '1; m_rel <= '0; m_bcl <= '1; m_cong <= 1'b0; m_cnt <= 0; m_bcnt <= 0;
      m_paused <= '0; m_preq <= '0; m_pmax <= '0;
    end else begin
      logic tk;
      logic adm;
      tk = m_cong && (m_cnt == RC - 1);
      if (cfg_we && cfg_addr == 2'd0) m_warn <= cfg_wdata;
      if (cfg_we && cfg_addr == 2'd1) m_rel <= cfg_wdata;
      if (cfg_we && cfg_addr == 2'd2) m_bcl <= cfg_wdata[BW-1:0];
      if (!m_cong && occ > m_warn) m_cong <= 1'b1;
      else if (m_cong && occ < rel_level(m_warn, m_rel)) m_cong <= 1'b0;
      m_cnt <= (!m_cong || tk) ? 0 : m_cnt + 1;
      for (int i = 0; i < NP; i++) begin
        m_preq[i] <= 1'b0; m_pmax[i] <= 1'b0;
        if (m_paused[i] && (!m_cong || !port_fdx[i])) begin
          m_preq[i] <= 1'b1; m_paused[i] <= 1'b0;
        end else if (m_paused[i] && tk) begin
          m_preq[i] <= 1'b1; m_pmax[i] <= 1'b1;
        end else if (!m_paused[i] && m_cong && port_fdx[i] && port_rx_busy[i]) begin
          m_preq[i] <= 1'b1; m_pmax[i] <= 1'b1; m_paused[i] <= 1'b1;
        end
      end
      adm = frm_valid && frm_bcast && (m_bcnt < int'(m_bcl));
      if (adm && !bc_free) m_bcnt <= m_bcnt + 1;
      else if (!adm && bc_free && m_bcnt > 0) m_bcnt <= m_bcnt - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (mon_en) begin
      logic [NP-1:0] jam_e;
      logic          drop_e;
      jam_e  = {NP{m_cong}} & ~port_fdx & port_rx_busy;
      drop_e = frm_valid && frm_bcast && (m_bcnt >= int'(m_bcl));
      chk(congested == m_cong, "R1/R2 congested", congested, m_cong);
      chk(jam_req == jam_e, "R4 jam_req", jam_req, jam_e);
      chk(pause_req == m_preq, "R5/R6/R7 pause_req", pause_req, m_preq);
      chk(pause_max == m_pmax, "R5/R7 pause_max", pause_max, m_pmax);
      chk(frm_drop == drop_e, "R8/R9 frm_drop", frm_drop, drop_e);
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input int v);
    cyc();
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = OW'(v);
    cyc();
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pulses;
    void'($urandom(32'd20240611));
    cyc(3);
    rst_n = 1'b1;
    cyc(5);
    // R12 reset state
    #2;
    chk(congested == 1'b0 && jam_req == '0 && pause_req == '0 && frm_drop == 1'b0,
        "R12 reset outputs", {congested, jam_req, pause_req}, 0);
    mon_en = 1'b1;
    // R11 write thresholds
    wr(2'd0, 100); wr(2'd1, 50); wr(2'd2, 3); wr(2'd3, 7);
    // R1: equal to the mark is not congestion
    cyc(); occ = 100; cyc(2); #2;
    chk(congested == 1'b0, "R1 at warning mark", congested, 0);
    cyc(); occ = 101; cyc(); #2;
    chk(congested == 1'b1, "R1 above warning mark", congested, 1);
    // R2 hysteresis
    cyc(); occ = 50; cyc(2); #2;
    chk(congested == 1'b1, "R2 hold at release mark", congested, 1);
    cyc(); occ = 49; cyc(); #2;
    chk(congested == 1'b0, "R2 release below mark", congested, 0);
    // R11 address 3 ignored: warning still 100
    cyc(); occ = 100; cyc(2); #2;
    chk(congested == 1'b0, "R11 unused address ignored", congested, 0);
    // R3 clamped release level: rel 200 >= warn 100 -> level 99
    wr(2'd1, 200);
    cyc(); occ = 150; cyc(2);
    occ = 99; cyc(2); #2;
    chk(congested == 1'b1, "R3 hold at warn-1", congested, 1);
    cyc(); occ = 98; cyc(); #2;
    chk(congested == 1'b0, "R3 release below warn-1", congested, 0);
    wr(2'd1, 50);
    // R5 R6: PAUSE on entry and refresh
    cyc(); occ = 0; port_fdx = '1; port_rx_busy = 12'h001; cyc(2);
    occ = 101;
    pulses = 0;
    for (int k = 0; k < 45; k++) begin
      cyc(); #2;
      if (pause_req[0] && pause_max[0]) pulses++;
    end
    chk(pulses == 3, "R6 entry plus refresh count", pulses, 3);
    chk(pause_req[5] == 1'b0, "R5 idle port not paused", pause_req[5], 0);
    // R4 jam on a half-duplex receiving port
    cyc(); port_fdx[1] = 1'b0; port_rx_busy[1] = 1'b1; #2;
    chk(jam_req[1] == 1'b1, "R4 jam while receiving", jam_req[1], 1);
    cyc(); port_rx_busy[1] = 1'b0; #2;
    chk(jam_req[1] == 1'b0, "R4 jam ends with frame", jam_req[1], 0);
    // R7 zero-time PAUSE on release
    cyc(); occ = 0; cyc(2); #2;
    chk(pause_req[0] == 1'b1 && pause_max[0] == 1'b0, "R7 zero pause on release",
        {pause_req[0], pause_max[0]}, 2);
    port_rx_busy = '0;
    // R8 R9 R10 broadcast limit 3
    for (int k = 0; k < 3; k++) begin
      cyc(); frm_valid = 1'b1; frm_bcast = 1'b1; #2;
      chk(frm_drop == 1'b0, "R10 admit below limit", frm_drop, 0);
    end
    cyc(); #2;
    chk(frm_drop == 1'b1, "R8 drop at limit", frm_drop, 1);
    cyc(); frm_bcast = 1'b0; #2;
    chk(frm_drop == 1'b0, "R9 non-broadcast kept", frm_drop, 0);
    cyc(); frm_valid = 1'b0; bc_free = 1'b1; cyc(6); bc_free = 1'b0;
    for (int k = 0; k < 4; k++) begin
      cyc(); frm_valid = 1'b1; frm_bcast = 1'b1; #2;
      chk(frm_drop == (k == 3), "R10 free saturates at zero", frm_drop, (k == 3));
    end
    cyc(); frm_valid = 1'b0; bc_free = 1'b1; cyc(4); bc_free = 1'b0;
    // random phase
    for (int n = 0; n < 6000; n++) begin
      cyc();
      cfg_we = 1'b0;
      if ($urandom_range(0, 199) == 0) begin
        cfg_we = 1'b1; cfg_addr = 2'($urandom_range(0, 3));
        cfg_wdata = OW'($urandom_range(0, 120));
      end
      occ = OW'($urandom_range(0, 127));
      if ($urandom_range(0, 3) != 0) occ = OW'((int'(occ) + 60) % 128);
      for (int p = 0; p < NP; p++) begin
        if ($urandom_range(0, 7) == 0) port_rx_busy[p] = ~port_rx_busy[p];
        if ($urandom_range(0, 299) == 0) port_fdx[p] = ~port_fdx[p];
      end
      frm_valid = ($urandom_range(0, 2) == 0);
      frm_bcast = $urandom_range(0, 1) == 1;
      bc_free   = ($urandom_range(0, 3) == 0);
    end
    cyc(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule